// File: doc/BRIEF.md
# Late-Write Pipelined Synchronous SRAM

This block is the front end of a single-clock pipelined static memory with deferred writes. A write cycle presents its address, write strobe and byte enables at one rising edge. The matching write data is taken at the following rising edge. Because write data trails its address by one cycle, a write can follow a read with no idle cycle on the shared data bus.

Each write is parked in a holding entry and does not reach the storage array in its own cycle. The entry stays parked through any number of reads and deselect cycles. When the data of the next write arrives, the parked entry is written to the array and the new write takes its place. Every read compares its address with the parked entry. On a match, the lanes enabled in the parked write are taken from the entry and the other lanes come from the array. The read result is registered, so read data follows the address with one cycle of pipeline delay.

Top module: `latewrite_sram`

## Requirements
- R1: While reset is held and after it is released, `rdata` is all zeros until the first read result lands.
- R2: The write data for a write cycle is the `wdata` value sampled at the rising edge after the one that sampled the write's address. `wdata` at any other edge has no effect on memory contents.
- R3: Read data for an address sampled at edge k appears on `rdata` after edge k+1.
- R4: A write may be issued in the cycle directly after a read with no idle cycle, and both complete correctly.
- R5: A parked write is written to the array only at the edge where the next write's data is taken. Reads of a displaced entry then return the same contents from the array.
- R6: A read returns the most recently written contents of its address. This includes a write whose data is taken at the same edge that samples the read address.
- R7: A hit merges per lane. Lane i covers bits [i*LANE_W +: LANE_W] and is governed by byte enable bit i. Enabled lanes of the parked write come from the holding entry, and the other lanes keep their older contents.
- R8: A cycle with `sel` low performs no access. It leaves any parked write unchanged and leaves `rdata` unchanged.
- R9: `rdata` changes only as the result of a read. Write and deselect cycles hold its previous value.
- R10: Once a write is parked, the pending flag stays set until reset. The entry is only ever replaced by a newer write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sel | input | 1 | Access select; low marks a deselect cycle |
| wr | input | 1 | High for a write, low for a read (when `sel` is high) |
| ben | input | LANES | Per-lane write enables for a write cycle |
| addr | input | ADDR_W | Word address |
| wdata | input | LANES*LANE_W | Write data, taken one cycle after its write's address |
| rdata | output | LANES*LANE_W | Registered read data |

## Verification
The bench builds the block with four 8-bit lanes and a 16-word array. The small array makes hits on the parked entry, and writes that displace it, happen often under random traffic. The four lanes give many partial-enable patterns, so the per-lane merge is exercised in most combinations. Directed sequences cover a read issued in the same cycle as a write's data, a write directly after a read, a partial write read back before and after it is displaced, and deselect cycles inserted between a write and its readback.

// File: rtl/lw_pkg.sv
package lw_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } lw_op_e;
endpackage

// File: rtl/lw_stage.sv
module lw_stage
  import lw_pkg::*;
#(
  parameter int AW = 6,
  parameter int NL = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel,
  input  logic          wr,
  input  logic [NL-1:0] ben,
  input  logic [AW-1:0] addr,
  output lw_op_e        op_q,
  output logic [AW-1:0] addr_q,
  output logic [NL-1:0] ben_q
);
  lw_op_e op_d;

  always_comb begin
    if (!sel)    op_d = OP_IDLE;
    else if (wr) op_d = OP_WRITE;
    else         op_d = OP_READ;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) op_q <= OP_IDLE;
    else        op_q <= op_d;
  end

  // address and enables load only on an access cycle
  always_ff @(posedge clk) begin
    if (sel) begin
      addr_q <= addr;
      ben_q  <= ben;
    end
  end
endmodule

// File: rtl/lw_hold.sv
module lw_hold #(
  parameter int AW = 6,
  parameter int NL = 2,
  parameter int LW = 9,
  localparam int DW = NL * LW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic [AW-1:0] take_addr,
  input  logic [NL-1:0] take_ben,
  input  logic [DW-1:0] take_data,
  output logic          pend,
  output logic [AW-1:0] hold_addr,
  output logic [NL-1:0] hold_ben,
  output logic [DW-1:0] hold_data,
  output logic          commit
);
  logic pend_d;

  always_comb begin
    pend_d = pend | take;
    commit = take & pend;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= 1'b0;
    else        pend <= pend_d;
  end

  always_ff @(posedge clk) begin
    if (take) begin
      hold_addr <= take_addr;
      hold_ben  <= take_ben;
      hold_data <= take_data;
    end
  end
endmodule

// File: rtl/lw_array.sv
module lw_array #(
  parameter int AW = 6,
  parameter int NL = 2,
  parameter int LW = 9,
  localparam int DEPTH = 1 << AW,
  localparam int DW    = NL * LW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [NL-1:0] wben,
  input  logic [DW-1:0] wdat,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdat
);
  for (genvar l = 0; l < NL; l++) begin : g_lane
    logic [LW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
      if (we && wben[l]) cells[waddr] <= wdat[l*LW +: LW];
    end

    assign rdat[l*LW +: LW] = cells[raddr];
  end
endmodule

// File: rtl/lw_merge.sv
module lw_merge #(
  parameter int NL = 2,
  parameter int LW = 9,
  localparam int DW = NL * LW
) (
  input  logic [DW-1:0] base,
  input  logic          hit,
  input  logic [NL-1:0] ovl_ben,
  input  logic [DW-1:0] ovl,
  output logic [DW-1:0] merged
);
  for (genvar l = 0; l < NL; l++) begin : g_lane
    assign merged[l*LW +: LW] = (hit && ovl_ben[l]) ? ovl[l*LW +: LW]
                                                     : base[l*LW +: LW];
  end
endmodule

// File: rtl/latewrite_sram.sv
module latewrite_sram
  import lw_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sel,
  input  logic                    wr,
  input  logic [LANES-1:0]        ben,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata
);
  localparam int DW = LANES * LANE_W;

  // reset: asserted at once, released after two clock edges
  logic [1:0] rst_pipe;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  lw_op_e              op_q;
  logic [ADDR_W-1:0]   addr_q;
  logic [LANES-1:0]    ben_q;
  logic                pend;
  logic [ADDR_W-1:0]   hold_addr;
  logic [LANES-1:0]    hold_ben;
  logic [DW-1:0]       hold_data;
  logic                commit;
  logic [DW-1:0]       arr_q;
  logic [DW-1:0]       merged;
  logic                rd_en;
  logic                hit;
  logic [DW-1:0]       rdata_d;

  lw_stage #(.AW(ADDR_W), .NL(LANES)) u_stage (
    .clk(clk), .rst_n(rst_int_n), .sel(sel), .wr(wr), .ben(ben), .addr(addr),
    .op_q(op_q), .addr_q(addr_q), .ben_q(ben_q)
  );

  lw_hold #(.AW(ADDR_W), .NL(LANES), .LW(LANE_W)) u_hold (
    .clk(clk), .rst_n(rst_int_n), .take(op_q == OP_WRITE),
    .take_addr(addr_q), .take_ben(ben_q), .take_data(wdata),
    .pend(pend), .hold_addr(hold_addr), .hold_ben(hold_ben),
    .hold_data(hold_data), .commit(commit)
  );

  lw_array #(.AW(ADDR_W), .NL(LANES), .LW(LANE_W)) u_array (
    .clk(clk), .we(commit), .waddr(hold_addr), .wben(hold_ben),
    .wdat(hold_data), .raddr(addr_q), .rdat(arr_q)
  );

  assign hit = pend && (hold_addr == addr_q);

  lw_merge #(.NL(LANES), .LW(LANE_W)) u_merge (
    .base(arr_q), .hit(hit), .ovl_ben(hold_ben), .ovl(hold_data),
    .merged(merged)
  );

  always_comb begin
    rd_en   = (op_q == OP_READ);
    rdata_d = rd_en ? merged : rdata;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) rdata <= '0;
    else            rdata <= rdata_d;
  end
endmodule

// File: rtl/lw_chk.sv
module lw_chk #(
  parameter int AW = 6,
  parameter int DW = 18
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sel,
  input logic          wr,
  input logic [DW-1:0] rdata,
  input logic          pend,
  input logic [AW-1:0] hold_addr,
  input logic          commit
);
  // R9
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel && !wr) |=> ##1 $stable(rdata));

  // R8
  hold_untouched_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel && wr) |=> ##1 $stable(hold_addr));

  // R5
  commit_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> $past(sel && wr));

  // R10
  pend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend |=> pend);

  // R2
  pend_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend) |-> $past(sel && wr, 2));
endmodule

bind latewrite_sram lw_chk #(.AW(ADDR_W), .DW(LANES*LANE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel(sel), .wr(wr), .rdata(rdata),
  .pend(pend), .hold_addr(hold_addr), .commit(commit)
);

// File: tb/sim_latewrite_sram.sv
`timescale 1ns/100ps
module sim_latewrite_sram;
  localparam int AW = 4;
  localparam int NL = 4;
  localparam int LW = 8;
  localparam int DW = NL * LW;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          sel;
  logic          wr;
  logic [NL-1:0] ben;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata;
  logic [DW-1:0] rdata;

  int checks = 0;
  int fails  = 0;

  logic [DW-1:0] model [DEPTH];
  bit            prev_wr = 0;
  logic [AW-1:0] prev_a;
  logic [NL-1:0] prev_b;
  logic [DW-1:0] prev_d;
  logic [DW-1:0] r1_d, r2_d, exp_out;
  bit            r1_v = 0, r2_v = 0;
  string         r1_t = "R9", r2_t = "R9";

  always #2.5 clk = ~clk;

  latewrite_sram #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) u0 (
    .clk(clk), .rst_n(rst_n), .sel(sel), .wr(wr), .ben(ben), .addr(addr),
    .wdata(wdata), .rdata(rdata)
  );

  task automatic check(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: rdata=%h expected=%h at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic logic [DW-1:0] lane_merge(input logic [DW-1:0] old,
      input logic [NL-1:0] b, input logic [DW-1:0] d);
    logic [DW-1:0] r = old;
    for (int l = 0; l < NL; l++) if (b[l]) r[l*LW +: LW] = d[l*LW +: LW];
    return r;
  endfunction

  // one bus cycle: inputs driven at the falling edge
  task automatic step(input bit s, input bit w, input logic [AW-1:0] a,
                      input logic [NL-1:0] b, input logic [DW-1:0] d, input string tag);
    @(negedge clk);
    if (r2_v) exp_out = r2_d;
    check(r2_t, rdata, exp_out);
    r2_v = r1_v; r2_d = r1_d; r2_t = r1_t;
    // data phase of the previous write (R2); otherwise junk that must be ignored
    if (prev_wr) begin
      wdata = prev_d;
      model[prev_a] = lane_merge(model[prev_a], prev_b, prev_d);
    end else begin
      wdata = $urandom;
    end
    sel = s; wr = w; addr = a; ben = b;
    r1_v = s && !w; r1_d = model[a]; r1_t = tag;
    prev_wr = s && w; prev_a = a; prev_b = b; prev_d = d;
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(0, 0, '0, '0, '0, tag);
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog: run did not complete, expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    exp_out = '0;
    rst_n = 1'b0; sel = 0; wr = 0; ben = '0; addr = '0; wdata = '0;
    repeat (3) @(posedge clk);
    #1 check("R1", rdata, '0);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1 check("R1", rdata, '0);
    idle(2, "R1");

    for (int i = 0; i < DEPTH; i++) step(1, 1, AW'(i), '1, DW'($urandom), "R9");
    for (int i = 0; i < DEPTH; i++) step(1, 0, AW'(i), '0, '0, "R6");

    // R6 / R3: read issued in the data cycle of a write to the same word
    step(1, 1, 4'd3, 4'hF, 32'hA1B2C3D4, "R9");
    step(1, 0, 4'd3, 4'h0, '0, "R6");
    step(1, 0, 4'd3, 4'h0, '0, "R3");
    // R4: write directly after a read, then read back
    step(1, 0, 4'd5, 4'h0, '0, "R4");
    step(1, 1, 4'd5, 4'hF, 32'h55AA1234, "R4");
    step(1, 0, 4'd5, 4'h0, '0, "R4");
    // R7: partial write hit, lanes 0 and 2 from the entry
    step(1, 1, 4'd7, 4'b0101, 32'hDEADBEEF, "R9");
    step(1, 0, 4'd7, 4'h0, '0, "R7");
    // R10: entry stays parked across many reads
    for (int i = 0; i < 6; i++) step(1, 0, AW'(i + 6), 4'h0, '0, "R10");
    step(1, 0, 4'd7, 4'h0, '0, "R10");
    // R5: next write displaces the entry into the array
    step(1, 1, 4'd9, 4'b1000, 32'h11223344, "R9");
    step(1, 0, 4'd7, 4'h0, '0, "R5");
    step(1, 0, 4'd9, 4'h0, '0, "R5");
    // R8: deselect between write and readback
    step(1, 1, 4'd2, 4'b0110, 32'hCAFEF00D, "R9");
    idle(4, "R8");
    step(1, 0, 4'd2, 4'h0, '0, "R8");
    idle(3, "R8");
    // R7: back-to-back writes to one word with different lanes
    step(1, 1, 4'd4, 4'b0001, 32'h000000AB, "R9");
    step(1, 1, 4'd4, 4'b1000, 32'hCD000000, "R9");
    step(1, 0, 4'd4, 4'h0, '0, "R7");

    for (int i = 0; i < 4000; i++) begin
      bit s = ($urandom % 10) != 0;
      bit w = $urandom % 2;
      step(s, w, AW'($urandom), NL'($urandom), DW'($urandom), "R6");
    end
    idle(4, "R9");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule